// File: doc/BRIEF.md
# Refresh Row Address Controller

This block supplies the row address for every refresh of a multiplexed-address dynamic memory array. It samples the row and column strobes on the system clock and recognises two kinds of refresh. In the first, the column strobe is already low when the row strobe falls, and the row comes from a 9-bit internal counter. This covers isolated refreshes, back-to-back pulses under one long column-strobe low, and hidden refreshes that follow a read. In the second, the row strobe pulses while the column strobe stays high, and the row is the one given on the address pins.

Each recognised refresh raises a request that carries the row and a flag naming its source. The request holds until the refresh engine acknowledges it. The internal counter moves to the next row only when an internal refresh is acknowledged. A power-up sequencer asserts a ready output after two steps: a quiet pause with both strobes high, then a set number of completed refreshes. A deadline watchdog then checks that every window of clock cycles sees at least one full sweep of rows, and raises a sticky flag if any window falls short.

Top module: `rfsh_addr_ctl`

## Requirements
- R1: While reset is applied and after it is released, `rfsh_req`, `part_ready` and `deadline_miss` read 0. The internal row counter starts at row 0.
- R2: A refresh from the counter is recognised at the clock edge where `ras_n` is first sampled low, provided `cas_n` was sampled low on at least CBR_SETUP consecutive earlier edges. From the next cycle on, `rfsh_req`=1, `rfsh_from_ctr`=1 and `rfsh_row` equals the counter value.
- R3: When `cas_n` was sampled low on fewer than CBR_SETUP edges before the falling `ras_n` edge, no request is raised for that row-strobe cycle, and the counter does not move.
- R4: When `cas_n` is high at every sample while `ras_n` is low, a request is raised at the edge where `ras_n` returns high. It carries `rfsh_from_ctr`=0 and `rfsh_row` equal to the `addr` value sampled at the falling `ras_n` edge. No request is raised while `ras_n` is low, and the counter is left unchanged.
- R5: A raised request keeps `rfsh_req`, `rfsh_row` and `rfsh_from_ctr` unchanged until `rfsh_done` is sampled high with it. `rfsh_req` is 0 on the following cycle. Strobe activity seen while a request is pending raises no further request.
- R6: The counter advances by one only when a request with `rfsh_from_ctr`=1 is acknowledged. It wraps from row 2^ROW_W-1 (511 by default) to row 0.
- R7: With `cas_n` held low, each falling edge of `ras_n` is a separate refresh. Successive requests carry consecutive counter rows.
- R8: In a hidden refresh, the read cycle that brings `cas_n` low while `ras_n` is low raises no request. The next falling edge of `ras_n`, with `cas_n` still low, raises a counter refresh.
- R9: The power-up pause ends only after PAUSE_CYC consecutive clock edges with both `ras_n` and `cas_n` sampled high. Any low strobe restarts the pause count. `part_ready` stays 0 throughout the pause, and refreshes completed during the pause do not count toward initialisation.
- R10: After the pause, `part_ready` rises once INIT_CYCLES refreshes have been acknowledged. When INIT_CBR_ONLY=1, only refreshes with `rfsh_from_ctr`=1 count. Once high, `part_ready` stays high until reset.
- R11: Once `part_ready` is high, time is split into windows of WINDOW_CYC cycles. `deadline_miss` is set at the end of a window that saw fewer than 2^ROW_W acknowledged refreshes of either source. It stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; strobes are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| addr | input | ROW_W | Multiplexed address bus; holds the row while the row strobe falls |
| rfsh_done | input | 1 | Acknowledge from the refresh engine for the pending request |
| rfsh_req | output | 1 | A refresh of `rfsh_row` is requested |
| rfsh_row | output | ROW_W | Row to refresh |
| rfsh_from_ctr | output | 1 | 1 when the row comes from the internal counter, 0 when it comes from the pins |
| part_ready | output | 1 | Power-up pause and initialisation refreshes are complete |
| deadline_miss | output | 1 | Sticky flag: some window saw fewer refreshes than there are rows |

## Verification
The assertions take the strobes as already synchronous to `clk`, and they take `rfsh_done` as meaningful only while a request is pending. They also take it that the refresh engine acknowledges each request before the next strobe event. The stimulus changes strobes and address only on falling clock edges. It always acknowledges a request before moving `ras_n` again, and it keeps `ras_n` high for at least one sample between pulses. Under those conditions every request is observed, served and released without any strobe event being dropped.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;
   typedef enum logic [1:0] {
      PU_PAUSE = 2'd0,
      PU_INIT  = 2'd1,
      PU_READY = 2'd2
   } pu_state_e;
endpackage

// File: rtl/rfsh_strobe_dec.sv
module rfsh_strobe_dec #(
   parameter int ROW_W     = 9,
   parameter int CBR_SETUP = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ras_n,
   input  logic             cas_n,
   input  logic [ROW_W-1:0] addr,
   output logic             cbr_evt,
   output logic             pins_evt,
   output logic [ROW_W-1:0] pins_row
);
   localparam int SW = $clog2(CBR_SETUP + 1);
   localparam logic [SW-1:0] SETUP_MAX = SW'(CBR_SETUP);

   logic          ras_d;
   logic [SW-1:0] cas_low_cnt;
   logic          cas_seen;
   logic          ras_fall;
   logic          ras_rise;

   assign ras_fall = ras_d & ~ras_n;
   assign ras_rise = ~ras_d & ras_n;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ras_d       <= 1'b1;
         cas_low_cnt <= '0;
         cas_seen    <= 1'b0;
         pins_row    <= '0;
      end else begin
         ras_d <= ras_n;
         if (cas_n)
            cas_low_cnt <= '0;
         else if (cas_low_cnt != SETUP_MAX)
            cas_low_cnt <= cas_low_cnt + 1'b1;
         if (ras_fall) begin
            pins_row <= addr;
            cas_seen <= ~cas_n;
         end else if (!ras_d && !cas_n) begin
            cas_seen <= 1'b1;
         end
      end
   end

   assign cbr_evt  = ras_fall & (cas_low_cnt == SETUP_MAX);
   assign pins_evt = ras_rise & ~cas_seen & cas_n;

   // R3
   setup_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cbr_evt |-> !$past(cas_n));

   // R4
   pins_after_cbr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cbr_evt |=> !pins_evt);
endmodule

// File: rtl/rfsh_row_ctr.sv
module rfsh_row_ctr #(
   parameter int ROW_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   output logic [ROW_W-1:0] row
);
   localparam logic [ROW_W-1:0] LAST_ROW = '1;

   always_ff @(posedge clk) begin
      if (!rst_n)
         row <= '0;
      else if (adv)
         row <= (row == LAST_ROW) ? '0 : row + 1'b1;
   end

   // R6
   wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && row == LAST_ROW) |=> row == '0);

   // R6
   counter_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |=> $stable(row));
endmodule

// File: rtl/rfsh_powerup.sv
module rfsh_powerup
   import rfsh_pkg::*;
#(
   parameter int PAUSE_CYC     = 20_000_000,
   parameter int INIT_CYCLES   = 8,
   parameter int INIT_CBR_ONLY = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ras_n,
   input  logic cas_n,
   input  logic done_evt,
   input  logic done_from_ctr,
   output logic ready
);
   localparam int PW = $clog2(PAUSE_CYC + 1);
   localparam int IW = $clog2(INIT_CYCLES + 1);
   localparam logic [PW-1:0] PAUSE_LAST = PW'(PAUSE_CYC - 1);
   localparam logic [IW-1:0] INIT_LAST  = IW'(INIT_CYCLES - 1);

   pu_state_e     st;
   logic [PW-1:0] pause_cnt;
   logic [IW-1:0] init_cnt;
   logic          counts;
   logic          idle;

   generate
      if (INIT_CBR_ONLY != 0) begin : g_ctr_only
         assign counts = done_evt & done_from_ctr;
      end else begin : g_any_src
         assign counts = done_evt;
      end
   endgenerate

   assign idle = ras_n & cas_n;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= PU_PAUSE;
         pause_cnt <= '0;
         init_cnt  <= '0;
      end else begin
         case (st)
            PU_PAUSE: begin
               if (!idle)
                  pause_cnt <= '0;
               else if (pause_cnt == PAUSE_LAST) begin
                  st        <= PU_INIT;
                  pause_cnt <= '0;
               end else
                  pause_cnt <= pause_cnt + 1'b1;
            end
            PU_INIT: begin
               if (counts) begin
                  if (init_cnt == INIT_LAST)
                     st <= PU_READY;
                  else
                     init_cnt <= init_cnt + 1'b1;
               end
            end
            default: ;
         endcase
      end
   end

   assign ready = (st == PU_READY);

   // R10
   ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ready |=> ready);

   // R9
   pause_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == PU_PAUSE && !idle) |=> st == PU_PAUSE);
endmodule

// File: rtl/rfsh_deadline_wd.sv
module rfsh_deadline_wd #(
   parameter int ROW_W      = 9,
   parameter int WINDOW_CYC = 800_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic done_evt,
   output logic miss
);
   localparam int ROWS = 1 << ROW_W;
   localparam int WW   = $clog2(WINDOW_CYC);
   localparam int CW   = $clog2(ROWS + 1);
   localparam logic [WW-1:0] WIN_LAST = WW'(WINDOW_CYC - 1);
   localparam logic [CW-1:0] CNT_SAT  = CW'(ROWS);

   logic [WW-1:0] win_cnt;
   logic [CW-1:0] done_cnt;
   logic [CW:0]   total;
   logic          win_end;

   assign total   = {1'b0, done_cnt} + (CW+1)'(done_evt);
   assign win_end = run && (win_cnt == WIN_LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         win_cnt  <= '0;
         done_cnt <= '0;
         miss     <= 1'b0;
      end else if (run) begin
         if (win_end) begin
            win_cnt  <= '0;
            done_cnt <= '0;
            if (total < (CW+1)'(ROWS))
               miss <= 1'b1;
         end else begin
            win_cnt <= win_cnt + 1'b1;
            if (done_evt && done_cnt != CNT_SAT)
               done_cnt <= done_cnt + 1'b1;
         end
      end
   end

   // R11
   miss_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      miss |=> miss);

   // R11
   no_early_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> !miss);
endmodule

// File: rtl/rfsh_addr_ctl.sv
module rfsh_addr_ctl #(
   parameter int ROW_W         = 9,
   parameter int CBR_SETUP     = 2,
   parameter int PAUSE_CYC     = 20_000_000,
   parameter int INIT_CYCLES   = 8,
   parameter int INIT_CBR_ONLY = 1,
   parameter int WINDOW_CYC    = 800_000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ras_n,
   input  logic             cas_n,
   input  logic [ROW_W-1:0] addr,
   input  logic             rfsh_done,
   output logic             rfsh_req,
   output logic [ROW_W-1:0] rfsh_row,
   output logic             rfsh_from_ctr,
   output logic             part_ready,
   output logic             deadline_miss
);
   generate
      if (ROW_W < 1 || ROW_W > 16) begin : g_bad_row_w
         $error("ROW_W must lie in 1..16");
      end
      if (CBR_SETUP < 1) begin : g_bad_setup
         $error("CBR_SETUP must be at least 1");
      end
      if (PAUSE_CYC < 1 || INIT_CYCLES < 1) begin : g_bad_powerup
         $error("PAUSE_CYC and INIT_CYCLES must be at least 1");
      end
      if (WINDOW_CYC < 2) begin : g_bad_window
         $error("WINDOW_CYC must be at least 2");
      end
   endgenerate

   logic             cbr_evt;
   logic             pins_evt;
   logic [ROW_W-1:0] pins_row;
   logic [ROW_W-1:0] ctr_row;
   logic             done_evt;
   logic             ctr_adv;

   assign done_evt = rfsh_req & rfsh_done;
   assign ctr_adv  = done_evt & rfsh_from_ctr;

   rfsh_strobe_dec #(.ROW_W(ROW_W), .CBR_SETUP(CBR_SETUP)) u_dec (
      .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .addr(addr),
      .cbr_evt(cbr_evt), .pins_evt(pins_evt), .pins_row(pins_row)
   );

   rfsh_row_ctr #(.ROW_W(ROW_W)) u_ctr (
      .clk(clk), .rst_n(rst_n), .adv(ctr_adv), .row(ctr_row)
   );

   rfsh_powerup #(
      .PAUSE_CYC(PAUSE_CYC), .INIT_CYCLES(INIT_CYCLES), .INIT_CBR_ONLY(INIT_CBR_ONLY)
   ) u_pwr (
      .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n),
      .done_evt(done_evt), .done_from_ctr(rfsh_from_ctr), .ready(part_ready)
   );

   rfsh_deadline_wd #(.ROW_W(ROW_W), .WINDOW_CYC(WINDOW_CYC)) u_wd (
      .clk(clk), .rst_n(rst_n), .run(part_ready), .done_evt(done_evt),
      .miss(deadline_miss)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rfsh_req      <= 1'b0;
         rfsh_row      <= '0;
         rfsh_from_ctr <= 1'b0;
      end else if (rfsh_req) begin
         if (rfsh_done)
            rfsh_req <= 1'b0;
      end else if (cbr_evt) begin
         rfsh_req      <= 1'b1;
         rfsh_row      <= ctr_row;
         rfsh_from_ctr <= 1'b1;
      end else if (pins_evt) begin
         rfsh_req      <= 1'b1;
         rfsh_row      <= pins_row;
         rfsh_from_ctr <= 1'b0;
      end
   end

   // R5
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rfsh_req && !rfsh_done) |=>
         (rfsh_req && $stable(rfsh_row) && $stable(rfsh_from_ctr)));

   // R5
   req_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rfsh_req && rfsh_done) |=> !rfsh_req);
endmodule

// File: tb/sim_rfsh_addr_ctl.sv
module sim_rfsh_addr_ctl;
   localparam int ROW_W  = 9;
   localparam int ROWS   = 1 << ROW_W;
   localparam int PAUSE  = 20;
   localparam int WINDOW = 6000;

   logic             clk = 1'b0;
   logic             rst_n;
   logic             ras_n;
   logic             cas_n;
   logic [ROW_W-1:0] addr;
   logic             rfsh_done;
   logic             rfsh_req;
   logic [ROW_W-1:0] rfsh_row;
   logic             rfsh_from_ctr;
   logic             part_ready;
   logic             deadline_miss;

   int  cyc = 0;
   int  errs = 0;
   int  checks = 0;
   int  exp_row = 0;
   int  rdy_cyc = 0;
   bit  finished = 1'b0;

   always #10 clk = ~clk;
   always @(posedge clk) cyc++;

   rfsh_addr_ctl #(
      .ROW_W(ROW_W), .CBR_SETUP(2), .PAUSE_CYC(PAUSE), .INIT_CYCLES(8),
      .INIT_CBR_ONLY(1), .WINDOW_CYC(WINDOW)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .addr(addr),
      .rfsh_done(rfsh_done), .rfsh_req(rfsh_req), .rfsh_row(rfsh_row),
      .rfsh_from_ctr(rfsh_from_ctr), .part_ready(part_ready),
      .deadline_miss(deadline_miss)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   // Called at the falling edge right after the event edge: check, hold, acknowledge.
   task automatic serve(input int row, input bit from_ctr, output bit ok, output int got);
      got = int'(rfsh_row);
      ok  = rfsh_req && (int'(rfsh_row) == row) && (rfsh_from_ctr == from_ctr);
      step(1);
      ok  = ok && rfsh_req && (int'(rfsh_row) == row);
      rfsh_done = 1'b1;
      step(1);
      rfsh_done = 1'b0;
      ok = ok && !rfsh_req;
   endtask

   task automatic cas_setup();
      cas_n = 1'b0;
      step(2);
   endtask

   // One row-strobe pulse under a column strobe already held low long enough.
   task automatic cbr_pulse(output bit ok, output int got, output int want);
      want  = exp_row;
      ras_n = 1'b0;
      step(1);
      serve(want, 1'b1, ok, got);
      ras_n = 1'b1;
      step(2);
      exp_row = (exp_row + 1) % ROWS;
   endtask

   task automatic pins_refresh(input int a, input int b, output bit ok, output int got);
      bit quiet;
      cas_n = 1'b1;
      addr  = ROW_W'(a);
      ras_n = 1'b0;
      step(1);
      addr  = ROW_W'(b);
      step(1);
      quiet = !rfsh_req;
      ras_n = 1'b1;
      step(1);
      serve(a, 1'b0, ok, got);
      ok = ok && quiet;
   endtask

   task automatic t_reset();
      rst_n = 1'b0; ras_n = 1'b1; cas_n = 1'b1; addr = '0; rfsh_done = 1'b0;
      step(3);
      chk(!rfsh_req && !part_ready && !deadline_miss, "R1 outputs in reset",
          int'({rfsh_req, part_ready, deadline_miss}), 0);
      rst_n = 1'b1;
      step(1);
      chk(!rfsh_req && !part_ready && !deadline_miss, "R1 outputs after reset",
          int'({rfsh_req, part_ready, deadline_miss}), 0);
   endtask

   task automatic t_pause_restart();
      bit ok; int got; int want; int bad = 0;
      step(12);
      pins_refresh(9'h055, 9'h1ff, ok, got);
      chk(ok, "R4 pins refresh during pause", got, 9'h055);
      step(12);
      cas_setup();
      cbr_pulse(ok, got, want);
      chk(ok, "R2 first counter refresh", got, want);
      for (int i = 1; i < 8; i++) begin
         cbr_pulse(ok, got, want);
         if (!ok) bad++;
      end
      cas_n = 1'b1;
      step(2);
      chk(bad == 0, "R2 refreshes during pause", bad, 0);
      chk(!part_ready, "R9 pause restarted by strobe activity", int'(part_ready), 0);
   endtask

   task automatic t_init();
      bit ok; int got; int want; int bad = 0;
      step(PAUSE + 5);
      chk(!part_ready, "R9 ready low after pause", int'(part_ready), 0);
      pins_refresh(9'h0a0, 9'h000, ok, got);
      chk(ok, "R4 pins refresh in init phase", got, 9'h0a0);
      cas_setup();
      for (int i = 0; i < 7; i++) begin
         cbr_pulse(ok, got, want);
         if (!ok) bad++;
      end
      cas_n = 1'b1;
      step(2);
      chk(bad == 0, "R10 init refresh rows", bad, 0);
      chk(!part_ready, "R10 ready low after 7 counter refreshes", int'(part_ready), 0);
      cas_setup();
      cbr_pulse(ok, got, want);
      chk(ok && part_ready, "R10 ready after 8th counter refresh", int'(part_ready), 1);
      rdy_cyc = cyc;
      cas_n = 1'b1;
      step(2);
   endtask

   task automatic t_wrap();
      bit ok; int got; int want; int bad = 0; bit saw_wrap = 1'b0;
      cas_setup();
      for (int i = 0; i < ROWS; i++) begin
         cbr_pulse(ok, got, want);
         if (!ok) bad++;
         if (want == 0) begin
            saw_wrap = 1'b1;
            chk(ok, "R6 row after 511 is 0", got, 0);
         end
      end
      cas_n = 1'b1;
      step(2);
      chk(bad == 0, "R7 back-to-back rows consecutive", bad, 0);
      chk(saw_wrap, "R6 wrap reached", int'(saw_wrap), 1);
   endtask

   task automatic t_window_ok();
      while (cyc < rdy_cyc + WINDOW + 5) step(1);
      chk(!deadline_miss, "R11 full sweep within window", int'(deadline_miss), 0);
   endtask

   task automatic t_pins_row();
      bit ok; int got; int want;
      pins_refresh(9'h1a3, 9'h0f0, ok, got);
      chk(ok, "R4 row latched at row-strobe fall", got, 9'h1a3);
      step(1);
      cas_setup();
      cbr_pulse(ok, got, want);
      chk(ok, "R6 counter unchanged by pins refresh", got, want);
      cas_n = 1'b1;
      step(2);
   endtask

   task automatic t_hidden();
      bit ok; int got; bit quiet;
      cas_n = 1'b1;
      addr  = 9'h077;
      ras_n = 1'b0;
      step(1);
      cas_n = 1'b0;
      step(3);
      ras_n = 1'b1;
      step(1);
      quiet = !rfsh_req;
      step(1);
      quiet = quiet && !rfsh_req;
      chk(quiet, "R8 read cycle raises no request", int'(rfsh_req), 0);
      ras_n = 1'b0;
      step(1);
      serve(exp_row, 1'b1, ok, got);
      chk(ok, "R8 hidden refresh from counter", got, exp_row);
      exp_row = (exp_row + 1) % ROWS;
      ras_n = 1'b1;
      step(2);
      cas_n = 1'b1;
      step(2);
   endtask

   task automatic t_short_setup();
      bit ok; int got; int want; bit quiet;
      cas_n = 1'b0;
      step(1);
      ras_n = 1'b0;
      step(1);
      quiet = !rfsh_req;
      step(2);
      quiet = quiet && !rfsh_req;
      ras_n = 1'b1;
      step(1);
      quiet = quiet && !rfsh_req;
      chk(quiet, "R3 short column setup raises no request", int'(rfsh_req), 0);
      cas_n = 1'b1;
      step(2);
      cas_setup();
      cbr_pulse(ok, got, want);
      chk(ok, "R3 counter unchanged by short setup", got, want);
      cas_n = 1'b1;
      step(2);
   endtask

   task automatic t_window_miss();
      while (cyc < rdy_cyc + 2 * WINDOW + 5) step(1);
      chk(deadline_miss, "R11 short window flagged", int'(deadline_miss), 1);
      chk(part_ready, "R10 ready stays high", int'(part_ready), 1);
   endtask

   initial begin
      t_reset();
      t_pause_restart();
      t_init();
      t_wrap();
      t_window_ok();
      t_pins_row();
      t_hidden();
      t_short_setup();
      t_window_miss();
      if (!finished) begin
         finished = 1'b1;
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         errs++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 200000);
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end
endmodule